// File: doc/BRIEF.md
# Indexed NAND Command Port Decoder

This block sits behind a pair of software-visible registers: a control word and a data port. Software loads a 32-bit address word into the control register, then performs one or more accesses to the data port. The address word selects an access mode, a target bank and a page or cycle selector. Each accepted data access is turned into exactly one typed request toward a NAND sequencer, which is offered on a valid/ready handshake. The meaning of a page-mode write depends on the value written, so the operation comes from the mode bits and the data value taken together.

Raw-cycle mode yields single command, address or read cycles on the flash bus. Page mode yields access-type selection, pipelined page transfers, block erase, lock and unlock, and the three follow-up words of a DMA descriptor. Streaming mode opens the data phase of a pipelined transfer on the control write alone, then moves whole 32-bit words through the data port. Illegal combinations raise a one-cycle error pulse and produce no request. While a request is still waiting, the bus is held off.

Top module: `nand_index_decoder`

## Requirements
- R1: The control word fields are: mode in bits [27:26] (01 streaming, 10 page, 11 raw), bank in bits [25:24], page in bits [23:0], and raw cycle selector in bits [1:0]. Every request carries the bank and page of the control word that produced it.
- R2: In raw mode, a data write with selector 0 issues kind 0 (command cycle) and with selector 1 issues kind 1 (address cycle). In both cases req_arg is the data byte wdata[7:0] zero-extended.
- R3: In raw mode, a data read with selector 2 issues kind 2 (read cycle). In streaming mode, a data read issues kind 15. One cycle after such a request is accepted, rd_valid pulses. For kind 2, bus_rdata then holds rsp_data[7:0] zero-extended; for kind 15 it holds the full rsp_data.
- R4: In page mode, a write of 0x41, 0x42 or 0x43 issues kind 3 and sets the access type to data[1:0] (1 spare only, 2 main only, 3 main plus spare). req_acc carries the access type in force for each request. The access type persists for later requests and is 2 after reset.
- R5: In page mode, a write with bit 13 set and bits [31:14] and [12:9] clear issues kind 4 (pipelined transfer). req_arg is the page count data[7:0], and req_write is data[8].
- R6: In page mode, the data values map to kinds as follows: 0x01 to kind 5 (block erase), 0x10 to kind 6 (unlock start), 0x11 to kind 7 (unlock end), 0x21 to kind 8 (lock), and 0x31 to kind 9 (lock-tight).
- R7: The DMA follow-up words must be page-mode writes in strict order after a pipelined-transfer write: 0x2200 (kind 10), then 0x2300 (kind 11), then 0x2400 (kind 12). Each carries control bits [23:8] in req_arg. A follow-up word out of this order is an error, and any other page-mode write breaks the chain.
- R8: A control write with mode 01 issues kind 13 (stream start) at once, carrying that word's bank and page. A streaming-mode data write issues kind 14 with the full 32-bit word in req_arg.
- R9: The following are errors: a data access in mode 00; a page-mode read; raw selector 3; a raw read with selector other than 2; a raw write with selector 2; an unrecognised page-mode value; and a read of the control register. Each error pulses err for one cycle, issues no request, and leaves the access type unchanged.
- R10: A request stays valid and unchanged until req_ready is high. bus_ready is low exactly while a request waits, and bus accesses are not taken while bus_ready is low.
- R11: With req_ready held high, back-to-back accepted accesses each produce their own request on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | 0 selects the control register, 1 the data port |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access is taken this cycle when high |
| bus_rdata | output | 32 | Read return data |
| rd_valid | output | 1 | bus_rdata is valid |
| err | output | 1 | One-cycle pulse after a rejected access |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted |
| req_kind | output | 4 | Request kind code |
| req_bank | output | 2 | Target bank |
| req_page | output | 24 | Page or cycle field |
| req_arg | output | 32 | Kind-specific argument |
| req_write | output | 1 | Pipelined transfer direction |
| req_acc | output | 2 | Access type in force |
| rsp_data | input | 32 | Read data from the sequencer |

## Verification
The assertions assume that bus_wr and bus_rd are never high together and that req_ready may change at any time. They also assume the consumer samples rsp_data in the cycle it accepts a read request. The stimulus raises only one strobe per access. It drives every input on the falling edge and holds an access until bus_ready lets it in. It drops req_ready on purpose only inside the stall test, so both the held request and the held bus access can be observed.

// File: rtl/nidx_pkg.sv
package nidx_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned PAGE_W  = 24;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned BANK_LO = 24;
  localparam int unsigned MODE_LO = BANK_LO + BANK_W;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned HALF_LO = 8;
  localparam int unsigned HALF_W  = PAGE_W - HALF_LO;

  typedef enum logic [3:0] {
    K_CMD = 4'd0, K_ADDR, K_RDCYC, K_ACCSEL, K_PIPE, K_ERASE, K_ULSTART,
    K_ULEND, K_LOCK, K_LOCKT, K_DMAHI, K_DMALO, K_DMAGO, K_STSTART,
    K_STDATA, K_STREAD
  } kind_e;

  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_SPARE, ACC_MAIN, ACC_BOTH} acc_e;
  typedef enum logic [1:0] {M_NONE = 2'd0, M_STREAM, M_PAGE, M_RAW} mode_e;

  typedef struct packed {
    mode_e             mode;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;
  } ctrl_t;

  typedef struct packed {
    kind_e             kind;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;
    logic [DW-1:0]     arg;
    logic              write;
    acc_e              acc;
  } req_t;
endpackage

// File: rtl/nidx_ctrl_reg.sv
module nidx_ctrl_reg
  import nidx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '{mode: M_NONE, bank: '0, page: '0};
    end else if (load) begin
      ctrl.mode <= mode_e'(wdata[MODE_LO +: 2]);
      ctrl.bank <= wdata[BANK_LO +: BANK_W];
      ctrl.page <= wdata[PAGE_W-1:0];
    end
  end
endmodule

// File: rtl/nidx_state.sv
module nidx_state
  import nidx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_we,
  input  acc_e       acc_d,
  input  logic       step_we,
  input  logic [1:0] step_d,
  output acc_e       acc_q,
  output logic [1:0] step_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= ACC_MAIN;
      step_q <= 2'd0;
    end else begin
      if (acc_we)  acc_q  <= acc_d;
      if (step_we) step_q <= step_d;
    end
  end

  // R4: access type is always one of the three legal selections
  p_acc_legal_r4: assert property (@(posedge clk) disable iff (rst)
    acc_q != ACC_NONE);

  // R7: descriptor chain only ever advances one word at a time
  p_dma_step_r7: assert property (@(posedge clk) disable iff (rst)
    (step_q > $past(step_q)) |-> (step_q == $past(step_q) + 2'd1));
endmodule

// File: rtl/nidx_decode.sv
module nidx_decode
  import nidx_pkg::*;
(
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  ctrl_t         ctrl,
  input  acc_e          acc_q,
  input  logic [1:0]    step_q,
  output logic          issue,
  output logic          bad,
  output req_t          req,
  output logic          acc_we,
  output acc_e          acc_d,
  output logic          step_we,
  output logic [1:0]    step_d
);
  logic is_pipe;
  assign is_pipe = wdata[13] && (wdata[DW-1:14] == '0) && (wdata[12:9] == '0);

  always_comb begin
    issue     = 1'b0;
    bad       = 1'b0;
    acc_we    = 1'b0;
    acc_d     = acc_q;
    step_we   = 1'b0;
    step_d    = 2'd0;
    req.kind  = K_CMD;
    req.bank  = ctrl.bank;
    req.page  = ctrl.page;
    req.arg   = '0;
    req.write = 1'b0;
    req.acc   = acc_q;
    if (!sel) begin
      if (wr_go && mode_e'(wdata[MODE_LO +: 2]) == M_STREAM) begin
        issue    = 1'b1;
        req.kind = K_STSTART;
        req.bank = wdata[BANK_LO +: BANK_W];
        req.page = wdata[PAGE_W-1:0];
      end else if (rd_go) begin
        bad = 1'b1;
      end
    end else if (wr_go || rd_go) begin
      case (ctrl.mode)
        M_RAW: begin
          case (ctrl.page[1:0])
            2'd0, 2'd1: begin
              if (wr_go) begin
                issue    = 1'b1;
                req.kind = (ctrl.page[0]) ? K_ADDR : K_CMD;
                req.arg  = {{(DW-8){1'b0}}, wdata[7:0]};
              end else bad = 1'b1;
            end
            2'd2: begin
              if (rd_go) begin
                issue    = 1'b1;
                req.kind = K_RDCYC;
              end else bad = 1'b1;
            end
            default: bad = 1'b1;
          endcase
        end
        M_PAGE: begin
          if (rd_go) begin
            bad = 1'b1;
          end else begin
            step_we = 1'b1;
            if (is_pipe) begin
              issue     = 1'b1;
              req.kind  = K_PIPE;
              req.arg   = {{(DW-CNT_W){1'b0}}, wdata[CNT_W-1:0]};
              req.write = wdata[8];
              step_d    = 2'd1;
            end else begin
              issue = 1'b1;
              case (wdata)
                32'h41, 32'h42, 32'h43: begin
                  req.kind = K_ACCSEL;
                  acc_we   = 1'b1;
                  acc_d    = acc_e'(wdata[1:0]);
                  req.acc  = acc_e'(wdata[1:0]);
                end
                32'h01: req.kind = K_ERASE;
                32'h10: req.kind = K_ULSTART;
                32'h11: req.kind = K_ULEND;
                32'h21: req.kind = K_LOCK;
                32'h31: req.kind = K_LOCKT;
                32'h2200, 32'h2300, 32'h2400: begin
                  req.arg = {{(DW-HALF_W){1'b0}}, ctrl.page[PAGE_W-1:HALF_LO]};
                  if (wdata[10] && step_q == 2'd3) begin
                    req.kind = K_DMAGO;
                  end else if (wdata[8] && !wdata[10] && step_q == 2'd2) begin
                    req.kind = K_DMALO;
                    step_d   = 2'd3;
                  end else if (!wdata[8] && !wdata[10] && step_q == 2'd1) begin
                    req.kind = K_DMAHI;
                    step_d   = 2'd2;
                  end else begin
                    issue = 1'b0;
                    bad   = 1'b1;
                  end
                end
                default: begin
                  issue = 1'b0;
                  bad   = 1'b1;
                end
              endcase
            end
          end
        end
        M_STREAM: begin
          issue    = 1'b1;
          req.kind = rd_go ? K_STREAD : K_STDATA;
          req.arg  = rd_go ? '0 : wdata;
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/nidx_req_stage.sv
module nidx_req_stage
  import nidx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          bad,
  input  req_t          req,
  input  logic          req_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          req_valid,
  output req_t          req_q,
  output logic          bus_ready,
  output logic          err,
  output logic          rd_valid,
  output logic [DW-1:0] rdata
);
  logic fire_rd;
  assign bus_ready = !req_valid || req_ready;
  assign fire_rd   = req_valid && req_ready &&
                     (req_q.kind == K_RDCYC || req_q.kind == K_STREAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_q     <= '{kind: K_CMD, bank: '0, page: '0, arg: '0, write: 1'b0, acc: ACC_MAIN};
      err       <= 1'b0;
      rd_valid  <= 1'b0;
      rdata     <= '0;
    end else begin
      err      <= bad;
      rd_valid <= fire_rd;
      if (fire_rd)
        rdata <= (req_q.kind == K_RDCYC) ? {{(DW-8){1'b0}}, rsp_data[7:0]} : rsp_data;
      if (issue) begin
        req_valid <= 1'b1;
        req_q     <= req;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  // R10: a waiting request keeps its payload
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_q)));

  // R9: a rejected access never loads a fresh request
  p_err_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    (err && req_valid) |-> $past(req_valid && !req_ready));
endmodule

// File: rtl/nand_index_decoder.sv
module nand_index_decoder
  import nidx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic [DW-1:0] bus_rdata,
  output logic          rd_valid,
  output logic          err,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [3:0]    req_kind,
  output logic [BANK_W-1:0] req_bank,
  output logic [PAGE_W-1:0] req_page,
  output logic [DW-1:0] req_arg,
  output logic          req_write,
  output logic [1:0]    req_acc,
  input  logic [DW-1:0] rsp_data
);
  logic       wr_go, rd_go, issue, bad, acc_we, step_we;
  logic [1:0] step_q, step_d;
  acc_e       acc_q, acc_d;
  ctrl_t      ctrl;
  req_t       req_n, req_q;

  assign wr_go = bus_wr && bus_ready;
  assign rd_go = bus_rd && !bus_wr && bus_ready;

  nidx_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .load(wr_go && !bus_sel), .wdata(bus_wdata), .ctrl(ctrl)
  );

  nidx_state u_state (
    .clk(clk), .rst(rst), .acc_we(acc_we), .acc_d(acc_d), .step_we(step_we),
    .step_d(step_d), .acc_q(acc_q), .step_q(step_q)
  );

  nidx_decode u_dec (
    .wr_go(wr_go), .rd_go(rd_go), .sel(bus_sel), .wdata(bus_wdata), .ctrl(ctrl),
    .acc_q(acc_q), .step_q(step_q), .issue(issue), .bad(bad), .req(req_n),
    .acc_we(acc_we), .acc_d(acc_d), .step_we(step_we), .step_d(step_d)
  );

  nidx_req_stage u_stage (
    .clk(clk), .rst(rst), .issue(issue), .bad(bad), .req(req_n),
    .req_ready(req_ready), .rsp_data(rsp_data), .req_valid(req_valid),
    .req_q(req_q), .bus_ready(bus_ready), .err(err), .rd_valid(rd_valid),
    .rdata(bus_rdata)
  );

  assign req_kind  = req_q.kind;
  assign req_bank  = req_q.bank;
  assign req_page  = req_q.page;
  assign req_arg   = req_q.arg;
  assign req_write = req_q.write;
  assign req_acc   = req_q.acc;

  // R4: a selection request reports the access type the state now holds
  p_accsel_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_q.kind == K_ACCSEL) |-> (req_q.acc == acc_q));
endmodule

// File: tb/tb_nand_index_decoder.sv
`timescale 1ns/1ps
module tb_nand_index_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rd_valid, err, req_valid, req_write;
  logic [31:0] bus_rdata, req_arg;
  logic        req_ready = 1'b1;
  logic [3:0]  req_kind;
  logic [1:0]  req_bank, req_acc;
  logic [23:0] req_page;
  logic [31:0] rsp_data = 32'hCAFE_BE5A;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  nand_index_decoder dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .err(err), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_bank(req_bank), .req_page(req_page), .req_arg(req_arg),
    .req_write(req_write), .req_acc(req_acc), .rsp_data(rsp_data)
  );

  localparam int NV = 16;
  localparam logic [31:0] V_CTRL [NV] = '{
    32'h0D000000, 32'h0E000001, 32'h0F000003, 32'h0C000002,
    32'h08000123, 32'h09000040, 32'h09000047, 32'h08000000,
    32'h0A000000, 32'h08000456, 32'h08000456, 32'h08000000,
    32'h00000010, 32'h08000000, 32'h05000010, 32'h08000000};
  localparam logic [31:0] V_DATA [NV] = '{
    32'h90, 32'h1A5, 32'h0, 32'h70, 32'h01, 32'h10, 32'h11, 32'h21,
    32'h31, 32'h2103, 32'h2001, 32'h55, 32'h90, 32'h0, 32'hDEADBEEF, 32'h2800};
  localparam logic V_RD  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,1,0,0};
  localparam logic V_ERR [NV] = '{0,0,1,1,0,0,0,0,0,0,0,1,1,1,0,1};
  localparam logic [3:0] V_KIND [NV] = '{0,1,0,0,5,6,7,8,9,4,4,0,0,0,14,0};
  localparam logic [31:0] V_ARG [NV] = '{
    32'h90, 32'hA5, 0, 0, 0, 0, 0, 0, 0, 32'h3, 32'h1, 0, 0, 0, 32'hDEADBEEF, 0};
  localparam logic V_WR [NV] = '{0,0,0,0,0,0,0,0,0,1,0,0,0,0,0,0};
  localparam string V_TAG [NV] = '{"R2","R2","R9","R9","R6","R6","R6","R6",
                                   "R6","R5","R5","R9","R9","R9","R8","R5"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic sel, input logic rd, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = !rd; bus_rd = rd; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic expect_req(input string tag, input logic [3:0] k, input logic [31:0] a);
    chk(tag, {31'b0, req_valid}, 32'd1);
    chk(tag, {28'b0, req_kind}, {28'b0, k});
    chk(tag, req_arg, a);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // reset state (R10, R4)
    chk("R10 reset valid", {31'b0, req_valid}, 0);
    chk("R10 reset ready", {31'b0, bus_ready}, 1);
    chk("R9 reset err", {31'b0, err}, 0);
    chk("R4 reset acc", {30'b0, req_acc}, 32'd2);

    // table walk (R1 fields checked on every request)
    for (int i = 0; i < NV; i++) begin
      acc(1'b0, 1'b0, V_CTRL[i]);
      chk({V_TAG[i], " ctrl-only"}, {31'b0, req_valid},
          {31'b0, (V_CTRL[i][27:26] == 2'b01)});
      if (V_CTRL[i][27:26] == 2'b01) begin
        chk("R8 start kind", {28'b0, req_kind}, 32'd13);
        chk("R8 start page", {8'b0, req_page}, {8'b0, V_CTRL[i][23:0]});
      end
      acc(1'b1, V_RD[i], V_DATA[i]);
      chk({V_TAG[i], " err"}, {31'b0, err}, {31'b0, V_ERR[i]});
      if (V_ERR[i]) begin
        chk({V_TAG[i], " no req"}, {31'b0, req_valid}, 0);
      end else begin
        expect_req(V_TAG[i], V_KIND[i], V_ARG[i]);
        chk({V_TAG[i], " write"}, {31'b0, req_write}, {31'b0, V_WR[i]});
        chk("R1 bank", {30'b0, req_bank}, {30'b0, V_CTRL[i][25:24]});
        chk("R1 page", {8'b0, req_page}, {8'b0, V_CTRL[i][23:0]});
      end
    end

    // R4 access type persistence; R9 rejected value leaves it alone
    acc(1'b0, 1'b0, 32'h08000000);
    acc(1'b1, 1'b0, 32'h41);
    expect_req("R4 sel spare", 4'd3, 0);
    chk("R4 sel acc", {30'b0, req_acc}, 32'd1);
    acc(1'b1, 1'b0, 32'h77);
    chk("R9 bad value err", {31'b0, err}, 1);
    acc(1'b1, 1'b0, 32'h2002);
    expect_req("R4 persists", 4'd4, 32'd2);
    chk("R9 acc unchanged", {30'b0, req_acc}, 32'd1);
    acc(1'b1, 1'b0, 32'h43);
    chk("R4 sel both", {30'b0, req_acc}, 32'd3);
    acc(1'b1, 1'b0, 32'h01);
    chk("R4 both persists", {30'b0, req_acc}, 32'd3);
    acc(1'b1, 1'b0, 32'h42);
    chk("R4 sel main", {30'b0, req_acc}, 32'd2);

    // R7 descriptor ordering
    acc(1'b0, 1'b0, 32'h08123400);
    acc(1'b1, 1'b0, 32'h2300);
    chk("R7 lo without chain", {31'b0, err}, 1);
    acc(1'b1, 1'b0, 32'h2001);
    expect_req("R7 head", 4'd4, 32'd1);
    acc(1'b1, 1'b0, 32'h2200);
    expect_req("R7 hi", 4'd10, 32'h1234);
    acc(1'b0, 1'b0, 32'h08567800);
    acc(1'b1, 1'b0, 32'h2300);
    expect_req("R7 lo", 4'd11, 32'h5678);
    acc(1'b0, 1'b0, 32'h08014000);
    acc(1'b1, 1'b0, 32'h2400);
    expect_req("R7 go", 4'd12, 32'h0140);
    acc(1'b1, 1'b0, 32'h2400);
    chk("R7 go repeated", {31'b0, err}, 1);
    acc(1'b1, 1'b0, 32'h2001);
    acc(1'b1, 1'b0, 32'h2400);
    chk("R7 go skips words", {31'b0, err}, 1);
    acc(1'b1, 1'b0, 32'h2001);
    acc(1'b1, 1'b0, 32'h21);
    acc(1'b1, 1'b0, 32'h2200);
    chk("R7 chain broken", {31'b0, err}, 1);

    // R3 raw read return
    acc(1'b0, 1'b0, 32'h0C000002);
    acc(1'b1, 1'b1, 32'h0);
    expect_req("R3 read cycle", 4'd2, 0);
    @(posedge clk); #1;
    chk("R3 rd_valid", {31'b0, rd_valid}, 1);
    chk("R3 rdata byte", bus_rdata, 32'h5A);
    acc(1'b1, 1'b0, 32'h5);
    chk("R9 raw write sel2", {31'b0, err}, 1);
    acc(1'b0, 1'b1, 32'h0);
    chk("R9 ctrl read", {31'b0, err}, 1);

    // R3/R8 streaming read
    acc(1'b0, 1'b0, 32'h04000000);
    acc(1'b1, 1'b1, 32'h0);
    expect_req("R3 stream read", 4'd15, 0);
    @(posedge clk); #1;
    chk("R3 stream rdata", bus_rdata, 32'hCAFEBE5A);

    // R10 stall and R11 back-to-back
    acc(1'b0, 1'b0, 32'h08000000);
    @(negedge clk); req_ready = 1'b0;
    acc(1'b1, 1'b0, 32'h21);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h31;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 bus held", {31'b0, bus_ready}, 0);
    chk("R10 req kept", {28'b0, req_kind}, 32'd8);
    chk("R10 valid kept", {31'b0, req_valid}, 1);
    @(negedge clk); req_ready = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    expect_req("R10 second taken", 4'd9, 0);
    acc(1'b1, 1'b0, 32'h10);
    expect_req("R11 first", 4'd6, 0);
    acc(1'b1, 1'b0, 32'h11);
    expect_req("R11 second", 4'd7, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule